// File: doc/BRIEF.md
# Serial Daisy-Chain Converter Front End

This block is the digital side of a 12-bit serial-input converter that sits in a chain of identical devices. Serial data enters a 12-bit shift register with the most significant bit first. Each bit pushed out of the top of that register goes to a registered serial output, which feeds the next device in the chain. A 12-bit holding register presents the converter code on a parallel port.

Four strobe pins can clock the shift register. Three of them act on a rising edge and one acts on a falling edge. The pins are merged into one composite strobe, and one small state machine watches it. In state `STB_IDLE` no strobe is asserted. When the composite becomes asserted, the *arm* transition moves the machine to `STB_HELD` and issues exactly one shift. The *release* transition returns it to `STB_IDLE` once every strobe is back at its idle level. While the machine is in `STB_HELD`, activity on any other strobe does nothing.

Every pin is sampled in one system clock domain through two-flop synchronizers. A shift therefore takes effect on the third rising clock edge after the strobe pin changes. The two active-low load pins copy the shift register into the holding register when both are low. The active-low clear pin empties the holding register at once.

Top module: `sdac_front`

## Requirements
- R1: After reset, `code` is 0x000 and `sdo` is 0. A load issued before any shift produces 0x000.
- R2: Each shift event moves `sdi` into bit 0 and moves every stored bit one place toward bit 11. After twelve shifts and a load, `code[11]` holds the first bit entered and `code[0]` holds the last.
- R3: After shift event n, `sdo` equals the `sdi` value taken at shift event n-12, so the serial output trails the input by exactly twelve events.
- R4: A shift is caused by a rising edge of `stb_a`, `stb_b` or `stb_d`, or by a falling edge of `stb_c_n`, when all other strobes are idle. The idle levels are low for `stb_a`, `stb_b` and `stb_d`, and high for `stb_c_n`. The shift lands on the third clock edge after the pin change.
- R5: While any strobe is held asserted, edges on the other strobes cause no shift. One shift occurs per idle-to-asserted change of the composite.
- R6: On a clock edge where both `ld_a_n` and `ld_b_n` are low, `code` takes the shift register value. If either load pin is high, `code` is unchanged.
- R7: A low `clr_n` forces `code` to 0x000 immediately, without waiting for a clock edge, and it overrides the load pins. The shift register and `sdo` keep their values.
- R8: Loads issued with no strobe activity change neither the shift register nor `sdo`.
- R9: When a shift and a load fall on the same clock edge, `code` takes the value the shift register held before that shift.
- R10: `sdo` changes only on a shift event and stays stable between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in, MSB first |
| stb_a | input | 1 | Strobe, rising-edge active |
| stb_b | input | 1 | Strobe, rising-edge active |
| stb_c_n | input | 1 | Strobe, falling-edge active |
| stb_d | input | 1 | Strobe, rising-edge active |
| ld_a_n | input | 1 | Load enable A, active low |
| ld_b_n | input | 1 | Load enable B, active low |
| clr_n | input | 1 | Asynchronous clear of the holding register, active low |
| sdo | output | 1 | Registered serial output to the next device |
| code | output | 12 | Holding register, the converter code |

## Verification
A shift and a load can land on the same clock edge. To provoke this, the bench pulls both load pins low in exactly the cycle that ends with the third edge after a strobe change. It then judges the result by requiring that `code` match the pre-shift contents, while a later load shows the new bit. A clear can also coincide with a pending load. The bench holds both load pins low under `clr_n` and expects zero, and after the clear is released it expects a load to recover the untouched shift contents.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int CODE_W  = 12;
    localparam int NUM_STB = 4;

    // Per-strobe idle level: index 2 is the falling-edge strobe.
    localparam logic [NUM_STB-1:0] STB_IDLE_LVL = 4'b0100;

    typedef enum logic [0:0] {
        STB_IDLE = 1'b0,
        STB_HELD = 1'b1
    } stb_state_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int N                = 5,
    parameter int STAGES           = 2,
    parameter logic [N-1:0] RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_LVL[i]}};
                else        chain <= {chain[STAGES-2:0], d_in[i]};
            end
            assign d_out[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sdac_strobe_fsm.sv
module sdac_strobe_fsm
    import sdac_pkg::*;
#(
    parameter int NS = NUM_STB,
    parameter logic [NS-1:0] IDLE_LVL = STB_IDLE_LVL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] stb_s,
    output logic          shift_pulse
);
    logic       comp;
    stb_state_t state, state_nx;

    // Any strobe away from its idle level asserts the composite.
    assign comp = |(stb_s ^ IDLE_LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= STB_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        shift_pulse = 1'b0;
        unique case (state)
            STB_IDLE: if (comp) begin
                state_nx    = STB_HELD;   // arm
                shift_pulse = 1'b1;
            end
            STB_HELD: if (!comp) state_nx = STB_IDLE;  // release
            default:  state_nx = STB_IDLE;
        endcase
    end

    AST_ONE_SHIFT_PER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse); // R5
    AST_NO_SHIFT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STB_HELD) |-> !shift_pulse); // R5
endmodule

// File: rtl/sdac_shift_chain.sv
module sdac_shift_chain #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sr,
    output logic         dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            dout <= 1'b0;
        end else if (shift_en) begin
            sr   <= {sr[W-2:0], din};
            dout <= sr[W-1];
        end
    end

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr[0] == $past(din))); // R2
    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(dout)); // R10
endmodule

// File: rtl/sdac_hold_reg.sv
module sdac_hold_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         ld_a_n,
    input  logic         ld_b_n,
    input  logic [W-1:0] sr,
    output logic [W-1:0] code
);
    logic arst_n;
    assign arst_n = rst_n & clr_n;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)               code <= '0;
        else if (!ld_a_n && !ld_b_n) code <= sr;
    end

    AST_LOAD_TAKES_SR: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!ld_a_n && !ld_b_n) |=> (code == $past(sr))); // R9
    AST_HOLD_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (ld_a_n || ld_b_n) |=> $stable(code)); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code == '0)); // R7
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int W      = CODE_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    input  logic         stb_a,
    input  logic         stb_b,
    input  logic         stb_c_n,
    input  logic         stb_d,
    input  logic         ld_a_n,
    input  logic         ld_b_n,
    input  logic         clr_n,
    output logic         sdo,
    output logic [W-1:0] code
);
    localparam int NSYNC = NUM_STB + 1;
    localparam logic [NSYNC-1:0] SYNC_RST = {1'b0, STB_IDLE_LVL};

    logic [NSYNC-1:0] raw, synced;
    logic [W-1:0]     sr;
    logic             shift_pulse;

    assign raw = {sdi, stb_d, stb_c_n, stb_b, stb_a};

    sdac_sync #(.N(NSYNC), .STAGES(STAGES), .RST_LVL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw), .d_out(synced)
    );

    sdac_strobe_fsm #(.NS(NUM_STB), .IDLE_LVL(STB_IDLE_LVL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .stb_s(synced[NUM_STB-1:0]),
        .shift_pulse(shift_pulse)
    );

    sdac_shift_chain #(.W(W)) u_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_pulse),
        .din(synced[NUM_STB]), .sr(sr), .dout(sdo)
    );

    sdac_hold_reg #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_a_n(ld_a_n),
        .ld_b_n(ld_b_n), .sr(sr), .code(code)
    );

    AST_LOAD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(sr)); // R8
endmodule

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        stb_a = 1'b0, stb_b = 1'b0, stb_c_n = 1'b1, stb_d = 1'b0;
    logic        ld_a_n = 1'b1, ld_b_n = 1'b1, clr_n = 1'b1;
    logic        sdo;
    logic [11:0] code;

    int checks = 0;
    int fails  = 0;
    logic [11:0] m_sr = '0, m_code = '0;
    logic        m_sdo = 1'b0;

    always #4 clk = ~clk;

    sdac_front u0 (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .stb_a(stb_a), .stb_b(stb_b),
        .stb_c_n(stb_c_n), .stb_d(stb_d), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n),
        .clr_n(clr_n), .sdo(sdo), .code(code)
    );

    function automatic logic [11:0] shifted(logic [11:0] s, logic b);
        return {s[10:0], b};
    endfunction

    task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_stb(int idx, logic on);
        case (idx)
            0: stb_a   = on;
            1: stb_b   = on;
            2: stb_c_n = !on;
            default: stb_d = on;
        endcase
    endtask

    // One shift through strobe idx carrying bit b.
    task automatic pulse(int idx, logic b);
        @(negedge clk);
        sdi = b;
        drive_stb(idx, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check("R10 sdo before shift", {11'b0, sdo}, {11'b0, m_sdo});
        m_sdo = m_sr[11];
        m_sr  = shifted(m_sr, b);
        @(negedge clk);
        check("R3 sdo after shift", {11'b0, sdo}, {11'b0, m_sdo});
        drive_stb(idx, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_load(logic a_n, logic b_n);
        @(negedge clk);
        ld_a_n = a_n;
        ld_b_n = b_n;
        @(negedge clk);
        ld_a_n = 1'b1;
        ld_b_n = 1'b1;
        if (!a_n && !b_n) m_code = m_sr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [11:0] word;
        void'($urandom(32'h5DAC));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code after reset", code, 12'h000);
        check("R1 sdo after reset", {11'b0, sdo}, 12'h000);
        do_load(1'b0, 1'b0);
        check("R1 load of reset shift register", code, 12'h000);

        // R2: twelve bits MSB first, then load
        word = 12'hA5C;
        for (int i = 11; i >= 0; i--) pulse(i % 4, word[i]);
        do_load(1'b0, 1'b0);
        check("R2 word assembled MSB first", code, 12'hA5C);

        // R3: next word pushes the previous one out MSB first
        word = 12'h3E1;
        for (int i = 11; i >= 0; i--) begin
            pulse(0, word[i]);
            check("R3 lagging bit", {11'b0, sdo}, {11'b0, m_sdo});
        end

        // R4: each strobe alone causes exactly one shift
        for (int k = 0; k < 4; k++) begin
            pulse(k, k[0]);
            do_load(1'b0, 1'b0);
            check("R4 shift per strobe", code, m_code);
        end

        // R5: other strobes toggled while one is held give no extra shift
        @(negedge clk);
        sdi = 1'b1;
        stb_b = 1'b1;
        repeat (4) @(negedge clk);
        m_sdo = m_sr[11];
        m_sr  = shifted(m_sr, 1'b1);
        sdi = 1'b0;
        stb_a = 1'b1; repeat (4) @(negedge clk);
        stb_c_n = 1'b0; repeat (4) @(negedge clk);
        stb_d = 1'b1; repeat (4) @(negedge clk);
        stb_a = 1'b0; stb_c_n = 1'b1; stb_d = 1'b0;
        repeat (4) @(negedge clk);
        stb_b = 1'b0;
        repeat (4) @(negedge clk);
        do_load(1'b0, 1'b0);
        check("R5 single shift under held strobe", code, m_code);
        check("R5 sdo single shift", {11'b0, sdo}, {11'b0, m_sdo});

        // R6: one load pin alone does nothing
        pulse(1, ~m_sr[0]);
        do_load(1'b0, 1'b1);
        check("R6 only ld_a_n low", code, m_code);
        do_load(1'b1, 1'b0);
        check("R6 only ld_b_n low", code, m_code);
        do_load(1'b0, 1'b0);
        check("R6 both low", code, m_sr);

        // R8: loads without strobes leave shift state alone
        for (int i = 0; i < 3; i++) do_load(1'b0, 1'b0);
        check("R8 sdo after loads", {11'b0, sdo}, {11'b0, m_sdo});
        pulse(3, 1'b0);
        do_load(1'b0, 1'b0);
        check("R8 shift register after loads", code, m_sr);

        // R7: asynchronous clear overrides load, shift register kept
        @(negedge clk);
        #1 clr_n = 1'b0;
        #1 check("R7 clear before edge", code, 12'h000);
        ld_a_n = 1'b0; ld_b_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 clear beats load", code, 12'h000);
        check("R7 sdo kept", {11'b0, sdo}, {11'b0, m_sdo});
        ld_a_n = 1'b1; ld_b_n = 1'b1;
        clr_n = 1'b1;
        do_load(1'b0, 1'b0);
        check("R7 shift register kept", code, m_sr);

        // R9: shift and load on the same edge
        word = m_sr;
        @(negedge clk);
        sdi = ~m_sr[0];
        stb_d = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ld_a_n = 1'b0; ld_b_n = 1'b0;
        @(negedge clk);
        ld_a_n = 1'b1; ld_b_n = 1'b1;
        m_sdo = m_sr[11];
        m_sr  = shifted(m_sr, sdi);
        check("R9 pre-shift value loaded", code, word);
        stb_d = 1'b0;
        repeat (3) @(negedge clk);
        do_load(1'b0, 1'b0);
        check("R9 shift still happened", code, m_sr);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            pulse(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 4) == 0) begin
                do_load(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                check("R6 random load", code, m_code);
            end
        end
        do_load(1'b0, 1'b0);
        check("R2 final random word", code, m_sr);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule